// File: doc/BRIEF.md
# Shadow Register Commit Controller

This block holds the configuration registers of a sensor timing generator. Each register has a pending shadow copy and an active copy that the pattern logic reads. A decoded host write strobe, raised when the last bit of a 28-bit serial word has been shifted in, always loads the shadow copy. The register's fixed commit class decides when the shadow copy reaches the active copy. There are five commit classes:

- **Immediate:** commits at once.
- **Frame:** commits at a frame-sync falling edge, or later on a programmed line.
- **Field:** commits at every frame-sync falling edge, whatever line delay is programmed.
- **Shutter:** commits on the line-sync falling edge that opens the sensor-gate line.
- **Sequence group:** commits at a change point where its group becomes active.

The sequence-group class covers a sequence and the pattern registers it references. A group commits only if it has been written since its last commit.

With default parameters the address map is fixed:

| Address | Class | Contents |
|---|---|---|
| 0 | immediate | line-delay value |
| 1 | immediate | sensor-gate line number |
| 2–3 | frame | data |
| 4 | field | data |
| 5–6 | shutter | data |
| 7–14 | sequence group | group g owns addresses 7+2g and 8+2g |

All other addresses are unused.

When a line-sync falling edge coincides with a change point, the block raises a write-inhibit flag so that the host holds back its writes.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: A write to address 0 or 1 appears on the active output at the clock edge that samples the strobe, so it is visible in the next cycle.
- R2: With the line-delay value at 0, a frame register (address 2 or 3) keeps its old active value across line-sync edges. It takes the shadow value at the edge that samples the frame sync falling (previous sample high, current sample low).
- R3: With the line-delay value N>0, a frame register does not commit at the frame-sync falling edge. It commits at the Nth line-sync falling edge after it.
- R4: The field register (address 4) commits at every frame-sync falling edge, whatever the line-delay value is.
- R5: Shutter registers (addresses 5, 6) commit only at a line-sync falling edge where the line counter input equals the active sensor-gate line number.
- R6: Sequence group g commits at a pulse on change-point bit g, and only if it was written since its last commit. Other groups are unaffected.
- R7: When a sequence register is written several times before its change point, the last value written is the one committed.
- R8: At a line-sync falling edge where any change-point bit is high, the inhibit flag goes high. It stays high for exactly 36 cycles after that edge, then drops.
- R9: When a write and a commit event for the same register fall in the same cycle, the previous shadow value is committed. The new value stays pending for the next event.
- R10: After reset, addresses 0 and 1 read 0, every other register reads 16'h5A5A, and the inhibit flag is low.
- R11: A write to an address of 15 or above changes no active value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Decoded write strobe, one cycle per serial word |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Write data |
| vd_i | input | 1 | Frame sync |
| hd_i | input | 1 | Line sync |
| line_cnt_i | input | 12 | Current line number |
| scp_i | input | 4 | Change-point pulse, one bit per sequence group |
| act_o | output | 240 | Active register values; register i at bits [16i+15:16i] |
| inhibit_o | output | 1 | Write-inhibit window flag |

## Verification
The assertions watch the hold conditions on every cycle. The field and frame copies may only move around a sync edge, shutter copies only at a line edge, and sequence copies only when a change-point bit is high. An immediate write must land in the following cycle, and a coinciding edge must raise the inhibit flag. Only the bench scenarios can show the rest: that a commit picks the right value, the line-delay count, the sensor-gate line match, last-write-wins, the same-cycle write rule and the exact 36-cycle inhibit length.

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl #(
  parameter int DW       = 16,
  parameter int LW       = 12,
  parameter int N_FRM    = 2,
  parameter int N_SHT    = 2,
  parameter int NGRP     = 4,
  parameter int PER_GRP  = 2,
  parameter int INH_CYC  = 36,
  parameter logic [DW-1:0] RST_WORD = 16'h5A5A,
  localparam int N_IMM    = 2,
  localparam int FLD      = N_IMM + N_FRM,
  localparam int SHT_BASE = FLD + 1,
  localparam int SEQ_BASE = SHT_BASE + N_SHT,
  localparam int NREG     = SEQ_BASE + NGRP * PER_GRP,
  localparam int AW       = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               vd_i,
  input  logic               hd_i,
  input  logic [LW-1:0]      line_cnt_i,
  input  logic [NGRP-1:0]    scp_i,
  output logic [NREG*DW-1:0] act_o,
  output logic               inhibit_o
);
  localparam int IW = $clog2(INH_CYC + 1);

  logic vd_q, hd_q, armed;
  logic [LW-1:0] lcnt;
  logic [IW-1:0] inh_cnt;
  logic [NGRP-1:0] pend, seq_go;

  wire vd_fall = vd_q & ~vd_i;
  wire hd_fall = hd_q & ~hd_i;
  wire [LW-1:0] dly = act_o[LW-1:0];
  wire [LW-1:0] sgl = act_o[DW+LW-1:DW];
  wire last_line = armed & hd_fall & (lcnt == LW'(1));
  wire frm_go = vd_fall ? (dly == '0) : last_line;
  wire sht_go = hd_fall & (line_cnt_i == sgl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vd_q <= 1'b0;
      hd_q <= 1'b0;
      armed <= 1'b0;
      lcnt <= '0;
      inh_cnt <= '0;
    end else begin
      vd_q <= vd_i;
      hd_q <= hd_i;
      if (vd_fall) begin
        armed <= (dly != '0);
        lcnt <= dly;
      end else if (armed && hd_fall) begin
        lcnt <= lcnt - LW'(1);
        if (last_line) armed <= 1'b0;
      end
      if (hd_fall && |scp_i) inh_cnt <= IW'(INH_CYC);
      else if (inh_cnt != '0) inh_cnt <= inh_cnt - IW'(1);
    end
  end

  assign inhibit_o = (inh_cnt != '0);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = SEQ_BASE + g * PER_GRP;
    wire grp_we = wr_en_i && (int'(wr_addr_i) >= LO) && (int'(wr_addr_i) < LO + PER_GRP);
    assign seq_go[g] = scp_i[g] & pend[g];
    always_ff @(posedge clk) begin
      if (!rst_n) pend[g] <= 1'b0;
      else if (grp_we) pend[g] <= 1'b1;
      else if (seq_go[g]) pend[g] <= 1'b0;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int CL = (i < N_IMM) ? 0 : (i < FLD) ? 1 : (i == FLD) ? 2 :
                        (i < SEQ_BASE) ? 3 : 4;
    localparam int GI = (i >= SEQ_BASE) ? (i - SEQ_BASE) / PER_GRP : 0;
    localparam logic [DW-1:0] RV = (i < N_IMM) ? '0 : RST_WORD;
    logic [DW-1:0] sh, ac;
    logic go;
    wire we = wr_en_i && (wr_addr_i == AW'(i));

    if (CL == 1)      assign go = frm_go;
    else if (CL == 2) assign go = vd_fall;
    else if (CL == 3) assign go = sht_go;
    else if (CL == 4) assign go = seq_go[GI];
    else              assign go = 1'b0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh <= RV;
        ac <= RV;
      end else begin
        if (we) sh <= wr_data_i;
        if (CL == 0 && we) ac <= wr_data_i;
        else if (go) ac <= sh;
      end
    end

    assign act_o[i*DW +: DW] = ac;
  end
endmodule

// File: rtl/shadow_commit_chk.sv
module shadow_commit_chk #(
  parameter int DW = 16,
  parameter int N_FRM = 2,
  parameter int N_SHT = 2,
  parameter int NGRP = 4,
  parameter int PER_GRP = 2,
  localparam int N_IMM = 2,
  localparam int FLD = N_IMM + N_FRM,
  localparam int SHT_BASE = FLD + 1,
  localparam int SEQ_BASE = SHT_BASE + N_SHT,
  localparam int NREG = SEQ_BASE + NGRP * PER_GRP,
  localparam int AW = $clog2(NREG + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en_i,
  input logic [AW-1:0]      wr_addr_i,
  input logic [DW-1:0]      wr_data_i,
  input logic               vd_i,
  input logic               hd_i,
  input logic [NGRP-1:0]    scp_i,
  input logic [NREG*DW-1:0] act_o,
  input logic               inhibit_o
);
  logic vq, hq;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vq <= 1'b0;
      hq <= 1'b0;
    end else begin
      vq <= vd_i;
      hq <= hd_i;
    end
  end
  wire vfall = vq & ~vd_i;
  wire hfall = hq & ~hd_i;

  AST_IMM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == '0) |=> act_o[DW-1:0] == $past(wr_data_i)); // R1
  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vfall && !hfall) |=> $stable(act_o[FLD*DW-1:N_IMM*DW])); // R3
  AST_FLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vfall |=> $stable(act_o[FLD*DW +: DW])); // R4
  AST_SHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hfall |=> $stable(act_o[SEQ_BASE*DW-1:SHT_BASE*DW])); // R5
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scp_i == '0) |=> $stable(act_o[NREG*DW-1:SEQ_BASE*DW])); // R6
  AST_INH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (hfall && scp_i != '0) |=> inhibit_o); // R8
endmodule

bind shadow_commit_ctrl shadow_commit_chk #(
  .DW(DW), .N_FRM(N_FRM), .N_SHT(N_SHT), .NGRP(NGRP), .PER_GRP(PER_GRP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .vd_i(vd_i), .hd_i(hd_i), .scp_i(scp_i),
  .act_o(act_o), .inhibit_o(inhibit_o)
);

// File: tb/shadow_commit_ctrl_bench.sv
module shadow_commit_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NREG = 15;
  localparam logic [15:0] DEF = 16'h5A5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic vd = 1'b1, hd = 1'b1;
  logic [11:0] line_cnt = '0;
  logic [3:0] scp = '0;
  logic [NREG*DW-1:0] act;
  logic inhibit;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_commit_ctrl u_shadow_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .vd_i(vd), .hd_i(hd), .line_cnt_i(line_cnt),
    .scp_i(scp), .act_o(act), .inhibit_o(inhibit)
  );

  task automatic check(input int idx, input logic [15:0] exp, input string req);
    checks++;
    if (act[idx*DW +: DW] !== exp) begin
      fails++;
      $display("FAIL %s reg %0d: actual %h expected %h", req, idx, act[idx*DW +: DW], exp);
    end
  endtask

  task automatic check_inh(input logic exp, input string req);
    checks++;
    if (inhibit !== exp) begin
      fails++;
      $display("FAIL %s inhibit: actual %b expected %b", req, inhibit, exp);
    end
  endtask

  task automatic write(input int a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic vd_pulse();
    vd = 1'b0; @(negedge clk); vd = 1'b1; @(negedge clk);
  endtask

  task automatic hd_pulse(input int ln);
    line_cnt = 12'(ln); hd = 1'b0; @(negedge clk); hd = 1'b1; @(negedge clk);
  endtask

  task automatic scp_pulse(input int g);
    scp = 4'(1 << g); @(negedge clk); scp = '0;
  endtask

  task automatic t_reset();
    check(0, 16'h0000, "R10");
    check(1, 16'h0000, "R10");
    for (int i = 2; i < NREG; i++) check(i, DEF, "R10");
    check_inh(1'b0, "R10");
  endtask

  task automatic t_immediate();
    write(1, 16'd3);
    check(1, 16'd3, "R1");
    write(0, 16'd0);
    check(0, 16'd0, "R1");
  endtask

  task automatic t_frame();
    write(2, 16'h1111);
    check(2, DEF, "R2 before edge");
    hd_pulse(0);
    check(2, DEF, "R2 after line edge");
    vd_pulse();
    check(2, 16'h1111, "R2");
  endtask

  task automatic t_delay_field();
    write(0, 16'd2);
    write(3, 16'h2222);
    write(4, 16'h4444);
    vd_pulse();
    check(4, 16'h4444, "R4");
    check(3, DEF, "R3 not at frame edge");
    hd_pulse(1);
    check(3, DEF, "R3 first line");
    hd_pulse(2);
    check(3, 16'h2222, "R3");
    write(0, 16'd0);
  endtask

  task automatic t_shutter();
    write(5, 16'h5555);
    hd_pulse(2);
    check(5, DEF, "R5 wrong line");
    vd_pulse();
    check(5, DEF, "R5 frame edge");
    hd_pulse(3);
    check(5, 16'h5555, "R5");
  endtask

  task automatic t_sequence();
    write(9, 16'h0101);
    write(9, 16'h0202);
    write(11, 16'h0303);
    scp_pulse(0);
    @(negedge clk);
    check(9, DEF, "R6 other group");
    check(11, DEF, "R6 other group");
    scp_pulse(1);
    @(negedge clk);
    check(9, 16'h0202, "R7");
    check(11, DEF, "R6 untouched");
    scp_pulse(2);
    @(negedge clk);
    check(11, 16'h0303, "R6");
  endtask

  task automatic t_inhibit();
    hd = 1'b0; scp = 4'b1000;
    @(negedge clk);
    hd = 1'b1; scp = '0;
    check_inh(1'b1, "R8 start");
    repeat (35) @(negedge clk);
    check_inh(1'b1, "R8 last cycle");
    @(negedge clk);
    check_inh(1'b0, "R8 end");
  endtask

  task automatic t_collision();
    write(2, 16'h7777);
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'h8888; vd = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; vd = 1'b1;
    @(negedge clk);
    check(2, 16'h7777, "R9 frame old value");
    vd_pulse();
    check(2, 16'h8888, "R9 frame pending");
    write(13, 16'h1313);
    wr_en = 1'b1; wr_addr = 4'd13; wr_data = 16'h1414; scp = 4'b1000;
    @(negedge clk);
    wr_en = 1'b0; scp = '0;
    check(13, 16'h1313, "R9 seq old value");
    scp_pulse(3);
    @(negedge clk);
    check(13, 16'h1414, "R9 seq pending");
  endtask

  task automatic t_bad_addr();
    logic [NREG*DW-1:0] snap;
    snap = act;
    write(15, 16'hFFFF);
    vd_pulse();
    hd_pulse(3);
    scp_pulse(0); scp_pulse(1); scp_pulse(2); scp_pulse(3);
    @(negedge clk);
    for (int i = 0; i < NREG; i++) check(i, snap[i*DW +: DW], "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_frame();
    t_delay_field();
    t_shutter();
    t_sequence();
    t_inhibit();
    t_collision();
    t_bad_addr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule